// File: doc/BRIEF.md
# Cross-Clock Mailbox Pair

This block lets two ports, each running on its own clock, pass single words to each other without using the bulk data queues. There are two one-word mailboxes, one for each direction. The first carries words from port A to port B. The second carries words from port B to port A. Each mailbox has an active-low full flag, and the flag is visible to the port that writes that mailbox.

A write loads the mailbox and pulls the flag low on the same edge. The flag stays low until the far port has read the word. The write event and the read event cross between the clock domains as toggles through synchronizer chains. Each side updates only its own state, so no event is lost and no register is driven from two domains.

A per-port mailbox select steers both reads and writes. When the select is high, a read shows the opposite mailbox on the port's output. When the select is low, the output shows the word from the queue's output register, which is an input to this block.

Top module: `mbx_pair`

## Requirements
- R1: While both resets are asserted, and after they are released, both full flags are high and both mailbox words read as zero.
- R2: A port A edge with aEn=1, aWrite=1 and aMbSel=1 while mail1FullN is high stores aDataIn as the A-to-B word. The same edge drives mail1FullN low.
- R3: While mail1FullN is low, port A mailbox writes are ignored. The stored A-to-B word keeps its value.
- R4: A port B edge with bEn=1, bWrite=0 and bMbSel=1 reads held A-to-B mail. After that edge, mail1FullN returns high within four rising edges of clkA, provided the word reached port B at least three clkB edges before the read.
- R5: The B-to-A mailbox mirrors R2 to R4. A port B write with bMbSel=1 sets mail2FullN low, and writes are ignored while it is low. A port A read (aEn=1, aWrite=0, aMbSel=1) releases mail2FullN within four clkB edges.
- R6: With the select high, aDataOut shows the B-to-A word and bDataOut shows the A-to-B word. With the select low, each output shows its queue input: aFifoData on port A, bFifoData on port B.
- R7: A mailbox read whose mail has not yet arrived in the reader's domain is not counted as a read. A write that follows it keeps the flag low until a later read.
- R8: rst1N low forces mail1FullN high and clears the A-to-B word without touching the B-to-A mailbox. rst2N does the same for the B-to-A mailbox only.
- R9: Port operations with the select low, or with the enable low, change neither mailbox word nor either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Port A clock |
| clkB | input | 1 | Port B clock |
| rst1N | input | 1 | Async active-low reset of the A-to-B mailbox (both domains) |
| rst2N | input | 1 | Async active-low reset of the B-to-A mailbox (both domains) |
| aEn | input | 1 | Port A operation enable |
| aWrite | input | 1 | Port A direction: 1 write, 0 read |
| aMbSel | input | 1 | Port A mailbox select |
| aDataIn | input | DATA_W | Port A write word |
| aFifoData | input | DATA_W | Queue output word shown on port A when the select is low |
| aDataOut | output | DATA_W | Port A read word |
| mail1FullN | output | 1 | A-to-B mailbox full flag, active low, clkA domain |
| bEn | input | 1 | Port B operation enable |
| bWrite | input | 1 | Port B direction: 1 write, 0 read |
| bMbSel | input | 1 | Port B mailbox select |
| bDataIn | input | DATA_W | Port B write word |
| bFifoData | input | DATA_W | Queue output word shown on port B when the select is low |
| bDataOut | output | DATA_W | Port B read word |
| mail2FullN | output | 1 | B-to-A mailbox full flag, active low, clkB domain |

## Verification
The main exchange is driven from a table of word pairs: zeros, ones, alternating bits, a walking one and arbitrary values. These patterns separate stuck, swapped or crossed data bits between the two mailboxes. Each pair is sent in both directions with unrelated clock periods, so flag release is checked across the synchronizers in both directions. Directed sequences then cover the following cases:
- a second write to a full mailbox, which must not overwrite the held word;
- a read that races ahead of the mail;
- select-low and enable-low traffic, which must leave the mailboxes alone;
- a reset of one mailbox while the other holds mail.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef struct packed {
    logic load1;   // clkA domain: capture aDataIn as the A-to-B word
    logic load2;   // clkB domain: capture bDataIn as the B-to-A word
    logic hold1N;  // A-to-B full flag (low while mail is held)
    logic hold2N;  // B-to-A full flag
  } mbx_strobe_t;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= 1'b0;
    else       chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[i] <= 1'b0;
      else       chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_chan.sv
module mbx_chan #(
  parameter int SYNC_STAGES = 2
) (
  input  logic wrClk,
  input  logic rdClk,
  input  logic rstN,
  input  logic wrReq,
  input  logic rdReq,
  output logic fullN,
  output logic load
);
  // writer domain
  logic setTgl, clrSyncW, clrSeenW, clrEvt, wrAcc;
  // reader domain
  logic clrTgl, setSyncR, setSeenR, setEvt, hasMail, rdAcc;

  assign wrAcc  = wrReq & fullN;
  assign clrEvt = clrSyncW ^ clrSeenW;
  assign load   = wrAcc;

  mbx_sync #(.STAGES(SYNC_STAGES)) u_clrSync (
    .clk(wrClk), .rstN(rstN), .d(clrTgl), .q(clrSyncW)
  );

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      fullN    <= 1'b1;
      setTgl   <= 1'b0;
      clrSeenW <= 1'b0;
    end else begin
      clrSeenW <= clrSyncW;
      if (wrAcc) begin
        fullN  <= 1'b0;
        setTgl <= ~setTgl;
      end else if (clrEvt) begin
        fullN  <= 1'b1;
      end
    end
  end

  assign setEvt = setSyncR ^ setSeenR;
  assign rdAcc  = rdReq & hasMail;

  mbx_sync #(.STAGES(SYNC_STAGES)) u_setSync (
    .clk(rdClk), .rstN(rstN), .d(setTgl), .q(setSyncR)
  );

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      hasMail  <= 1'b0;
      clrTgl   <= 1'b0;
      setSeenR <= 1'b0;
    end else begin
      setSeenR <= setSyncR;
      if (rdAcc) begin
        hasMail <= 1'b0;
        clrTgl  <= ~clrTgl;
      end else if (setEvt) begin
        hasMail <= 1'b1;
      end
    end
  end

  // R2: an accepted write leaves the flag low
  p_flag_low_after_write_r2: assert property (
    @(posedge wrClk) disable iff (!rstN) (wrReq && fullN) |=> !fullN);

  // R4: a release only ever arrives while mail is held
  p_release_while_full_r4: assert property (
    @(posedge wrClk) disable iff (!rstN) clrEvt |-> !fullN);

  // R7: new mail never arrives at a reader that still counts a held word
  p_arrive_when_idle_r7: assert property (
    @(posedge rdClk) disable iff (!rstN) setEvt |-> !hasMail);
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clkA,
  input  logic        clkB,
  input  logic        rst1N,
  input  logic        rst2N,
  input  logic        aEn,
  input  logic        aWrite,
  input  logic        aMbSel,
  input  logic        bEn,
  input  logic        bWrite,
  input  logic        bMbSel,
  output mbx_strobe_t strb
);
  logic aMbWr, aMbRd, bMbWr, bMbRd;
  logic full1N, full2N, load1, load2;

  assign aMbWr = aEn &  aWrite & aMbSel;
  assign aMbRd = aEn & ~aWrite & aMbSel;
  assign bMbWr = bEn &  bWrite & bMbSel;
  assign bMbRd = bEn & ~bWrite & bMbSel;

  mbx_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chanAtoB (
    .wrClk(clkA), .rdClk(clkB), .rstN(rst1N),
    .wrReq(aMbWr), .rdReq(bMbRd), .fullN(full1N), .load(load1)
  );

  mbx_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chanBtoA (
    .wrClk(clkB), .rdClk(clkA), .rstN(rst2N),
    .wrReq(bMbWr), .rdReq(aMbRd), .fullN(full2N), .load(load2)
  );

  always_comb begin
    strb.load1  = load1;
    strb.load2  = load2;
    strb.hold1N = full1N;
    strb.hold2N = full2N;
  end
endmodule

// File: rtl/mbx_data.sv
module mbx_data
  import mbx_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rst1N,
  input  logic              rst2N,
  input  mbx_strobe_t       strb,
  input  logic              aMbSel,
  input  logic              bMbSel,
  input  logic [DATA_W-1:0] aDataIn,
  input  logic [DATA_W-1:0] bDataIn,
  input  logic [DATA_W-1:0] aFifoData,
  input  logic [DATA_W-1:0] bFifoData,
  output logic [DATA_W-1:0] aDataOut,
  output logic [DATA_W-1:0] bDataOut
);
  logic [DATA_W-1:0] mail1Q, mail2Q;

  always_ff @(posedge clkA or negedge rst1N) begin
    if (!rst1N)         mail1Q <= '0;
    else if (strb.load1) mail1Q <= aDataIn;
  end

  always_ff @(posedge clkB or negedge rst2N) begin
    if (!rst2N)         mail2Q <= '0;
    else if (strb.load2) mail2Q <= bDataIn;
  end

  assign aDataOut = aMbSel ? mail2Q : aFifoData;
  assign bDataOut = bMbSel ? mail1Q : bFifoData;

  // R3: the held A-to-B word stays put while its flag is low
  p_hold_mail1_r3: assert property (
    @(posedge clkA) disable iff (!rst1N) !strb.hold1N |=> $stable(mail1Q));

  // R5: the held B-to-A word stays put while its flag is low
  p_hold_mail2_r5: assert property (
    @(posedge clkB) disable iff (!rst2N) !strb.hold2N |=> $stable(mail2Q));
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
  import mbx_pkg::*;
#(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rst1N,
  input  logic              rst2N,
  input  logic              aEn,
  input  logic              aWrite,
  input  logic              aMbSel,
  input  logic [DATA_W-1:0] aDataIn,
  input  logic [DATA_W-1:0] aFifoData,
  output logic [DATA_W-1:0] aDataOut,
  output logic              mail1FullN,
  input  logic              bEn,
  input  logic              bWrite,
  input  logic              bMbSel,
  input  logic [DATA_W-1:0] bDataIn,
  input  logic [DATA_W-1:0] bFifoData,
  output logic [DATA_W-1:0] bDataOut,
  output logic              mail2FullN
);
  mbx_strobe_t strb;

  mbx_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clkA(clkA), .clkB(clkB), .rst1N(rst1N), .rst2N(rst2N),
    .aEn(aEn), .aWrite(aWrite), .aMbSel(aMbSel),
    .bEn(bEn), .bWrite(bWrite), .bMbSel(bMbSel),
    .strb(strb)
  );

  mbx_data #(.DATA_W(DATA_W)) u_data (
    .clkA(clkA), .clkB(clkB), .rst1N(rst1N), .rst2N(rst2N),
    .strb(strb), .aMbSel(aMbSel), .bMbSel(bMbSel),
    .aDataIn(aDataIn), .bDataIn(bDataIn),
    .aFifoData(aFifoData), .bFifoData(bFifoData),
    .aDataOut(aDataOut), .bDataOut(bDataOut)
  );

  assign mail1FullN = strb.hold1N;
  assign mail2FullN = strb.hold2N;
endmodule

// File: tb/mbx_pair_bench.sv
module mbx_pair_bench;
  localparam int CLK_A_PERIOD = 10;
  localparam int CLK_B_PERIOD = 14;
  localparam int W = 36;
  localparam int NVEC = 6;
  localparam logic [2*W-1:0] VECS [NVEC] = '{
    {36'h0_0000_0000, 36'h0_0000_0000},
    {36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF},
    {36'hA_AAAA_AAAA, 36'h5_5555_5555},
    {36'h8_0000_0001, 36'h0_0000_0010},
    {36'h1_2345_6789, 36'hE_DCBA_9876},
    {36'h3_0C0F_F00C, 36'hC_F3F0_0FF3}
  };

  logic clkA = 1'b0, clkB = 1'b0;
  logic rst1N = 1'b0, rst2N = 1'b0;
  logic aEn = 0, aWrite = 0, aMbSel = 0;
  logic bEn = 0, bWrite = 0, bMbSel = 0;
  logic [W-1:0] aDataIn = '0, bDataIn = '0;
  logic [W-1:0] aFifoData = 36'h1_1111_1111, bFifoData = 36'h2_2222_2222;
  logic [W-1:0] aDataOut, bDataOut;
  logic mail1FullN, mail2FullN;

  int nChecks = 0, nFails = 0;

  always #(CLK_A_PERIOD/2) clkA = ~clkA;
  always #(CLK_B_PERIOD/2) clkB = ~clkB;

  mbx_pair #(.DATA_W(W), .SYNC_STAGES(2)) u_mbx_pair (
    .clkA(clkA), .clkB(clkB), .rst1N(rst1N), .rst2N(rst2N),
    .aEn(aEn), .aWrite(aWrite), .aMbSel(aMbSel), .aDataIn(aDataIn),
    .aFifoData(aFifoData), .aDataOut(aDataOut), .mail1FullN(mail1FullN),
    .bEn(bEn), .bWrite(bWrite), .bMbSel(bMbSel), .bDataIn(bDataIn),
    .bFifoData(bFifoData), .bDataOut(bDataOut), .mail2FullN(mail2FullN)
  );

  task automatic check(input logic ok, input string req,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic aOp(input logic wr, input logic sel, input logic [W-1:0] d,
                     output logic [W-1:0] seen);
    @(negedge clkA);
    aEn = 1; aWrite = wr; aMbSel = sel; aDataIn = d;
    #1 seen = aDataOut;
    @(negedge clkA);
    aEn = 0; aWrite = 0; aMbSel = 0;
  endtask

  task automatic bOp(input logic wr, input logic sel, input logic [W-1:0] d,
                     output logic [W-1:0] seen);
    @(negedge clkB);
    bEn = 1; bWrite = wr; bMbSel = sel; bDataIn = d;
    #1 seen = bDataOut;
    @(negedge clkB);
    bEn = 0; bWrite = 0; bMbSel = 0;
  endtask

  task automatic waitFlag1High(input string req);
    logic got = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clkA);
      if (mail1FullN) begin got = 1; break; end
    end
    check(got, req, {35'd0, mail1FullN}, 36'd1);
  endtask

  task automatic waitFlag2High(input string req);
    logic got = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clkB);
      if (mail2FullN) begin got = 1; break; end
    end
    check(got, req, {35'd0, mail2FullN}, 36'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clkA);
    nFails++; nChecks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [W-1:0] seen, wA, wB;
    repeat (3) @(negedge clkB);
    // R1: flags and words during reset
    aMbSel = 1; bMbSel = 1; #1;
    check(mail1FullN && mail2FullN, "R1 flags in reset", {34'd0, mail1FullN, mail2FullN}, 36'd3);
    check(aDataOut == '0 && bDataOut == '0, "R1 words in reset", aDataOut | bDataOut, '0);
    aMbSel = 0; bMbSel = 0;
    rst1N = 1; rst2N = 1;
    repeat (2) @(negedge clkB);
    check(mail1FullN && mail2FullN, "R1 flags after reset", {34'd0, mail1FullN, mail2FullN}, 36'd3);

    // R6: select low shows queue words
    #1 check(aDataOut == aFifoData, "R6 port A select low", aDataOut, aFifoData);
    check(bDataOut == bFifoData, "R6 port B select low", bDataOut, bFifoData);

    // Vector table: exchange in both directions (R2, R4, R5, R6)
    for (int v = 0; v < NVEC; v++) begin
      wA = VECS[v][2*W-1:W];
      wB = VECS[v][W-1:0];
      aOp(1, 1, wA, seen);
      check(!mail1FullN, "R2 flag low after write", {35'd0, mail1FullN}, 36'd0);
      bOp(1, 1, wB, seen);
      check(!mail2FullN, "R5 flag low after write", {35'd0, mail2FullN}, 36'd0);
      repeat (5) @(negedge clkB);
      bOp(0, 1, '0, seen);
      check(seen == wA, "R6 port B reads A-to-B word", seen, wA);
      waitFlag1High("R4 release after port B read");
      aOp(0, 1, '0, seen);
      check(seen == wB, "R6 port A reads B-to-A word", seen, wB);
      waitFlag2High("R5 release after port A read");
    end

    // R3: second write while full is ignored
    aOp(1, 1, 36'h0_DEAD_0001, seen);
    aOp(1, 1, 36'h0_BEEF_0002, seen);
    check(!mail1FullN, "R3 flag stays low", {35'd0, mail1FullN}, 36'd0);
    repeat (5) @(negedge clkB);
    bOp(0, 1, '0, seen);
    check(seen == 36'h0_DEAD_0001, "R3 held word kept", seen, 36'h0_DEAD_0001);
    waitFlag1High("R4 release after R3 read");

    // R5 mirror: second port B write ignored
    bOp(1, 1, 36'h7_0000_0007, seen);
    bOp(1, 1, 36'h9_0000_0009, seen);
    repeat (5) @(negedge clkA);
    aOp(0, 1, '0, seen);
    check(seen == 36'h7_0000_0007, "R5 held word kept", seen, 36'h7_0000_0007);
    waitFlag2High("R5 release after mirror read");

    // R7: early read does not count; write right after stays full
    bOp(0, 1, '0, seen);
    aOp(1, 1, 36'h4_4444_4444, seen);
    begin
      logic stayedLow = 1;
      for (int i = 0; i < 12; i++) begin
        @(negedge clkA);
        if (mail1FullN) stayedLow = 0;
      end
      check(stayedLow, "R7 flag held after early read", {35'd0, mail1FullN}, 36'd0);
    end
    bOp(0, 1, '0, seen);
    check(seen == 36'h4_4444_4444, "R7 word delivered", seen, 36'h4_4444_4444);
    waitFlag1High("R7 release after real read");

    // R9: select-low write and enable-low write leave mailbox alone
    aOp(1, 0, 36'h5_0000_0005, seen);
    check(mail1FullN, "R9 select-low write no flag", {35'd0, mail1FullN}, 36'd1);
    @(negedge clkA);
    aEn = 0; aWrite = 1; aMbSel = 1; aDataIn = 36'h6_0000_0006;
    @(negedge clkA);
    aWrite = 0; aMbSel = 0;
    check(mail1FullN, "R9 enable-low write no flag", {35'd0, mail1FullN}, 36'd1);
    @(negedge clkB); bMbSel = 1; #1;
    check(bDataOut == 36'h4_4444_4444, "R9 word unchanged", bDataOut, 36'h4_4444_4444);
    bMbSel = 0;
    // R9: select-low read while mail is held does not release
    aOp(1, 1, 36'h0_1234_5678, seen);
    repeat (5) @(negedge clkB);
    bOp(0, 0, '0, seen);
    check(seen == bFifoData, "R9 select-low read shows queue", seen, bFifoData);
    repeat (8) @(negedge clkA);
    check(!mail1FullN, "R9 select-low read keeps flag", {35'd0, mail1FullN}, 36'd0);

    // R8: reset A-to-B only while both hold mail
    bOp(1, 1, 36'hB_0000_000B, seen);
    repeat (5) @(negedge clkA);
    @(negedge clkA); rst1N = 0;
    repeat (2) @(negedge clkB);
    #1 check(mail1FullN, "R8 rst1N sets flag", {35'd0, mail1FullN}, 36'd1);
    bMbSel = 1; #1;
    check(bDataOut == '0, "R8 rst1N clears word", bDataOut, '0);
    bMbSel = 0;
    check(!mail2FullN, "R8 rst1N spares B-to-A flag", {35'd0, mail2FullN}, 36'd0);
    rst1N = 1;
    aMbSel = 1; #1;
    check(aDataOut == 36'hB_0000_000B, "R8 rst1N spares B-to-A word", aDataOut, 36'hB_0000_000B);
    aMbSel = 0;
    @(negedge clkB); rst2N = 0;
    repeat (2) @(negedge clkA);
    #1 check(mail2FullN, "R8 rst2N sets flag", {35'd0, mail2FullN}, 36'd1);
    aMbSel = 1; #1;
    check(aDataOut == '0, "R8 rst2N clears word", aDataOut, '0);
    aMbSel = 0;
    rst2N = 1;
    repeat (3) @(negedge clkA);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule